// File: doc/BRIEF.md
# Invalidation Queue Descriptor Checker

This block inspects one 128-bit descriptor at a time, as taken from an invalidation queue, and applies the legality rules of two descriptor kinds. A wait (barrier) descriptor is only checked. It is legal when at least one of its three flags is set: interrupt, status write or fence. A page group response descriptor is checked for reserved bits and for the PASID-present bit. When it is legal, it is decoded into a single-cycle response event for the device that raised the page request. That event carries the requester ID, the PASID, the group index and a mapped response code.

Every other descriptor type passes through without any reaction. Both results are registered, so they appear one clock after the input strobe. Each result lasts exactly one cycle. Descriptors are handled strictly in order, so a fence-only wait needs no further action here.

Top module: `iq_desc_checker`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, `bad_desc` and `rsp_vld` are 0.
- R2: A strobed wait descriptor (type code 4'h5) whose flag bits `desc_lo[6:4]` (bit 4 interrupt, bit 5 status write, bit 6 fence) are all 0 raises `bad_desc` in the next cycle.
- R3: A wait descriptor with any non-zero flag combination, including fence only (bit 6 alone), gives `bad_desc`=0 and `rsp_vld`=0.
- R4: A page group response (type code 4'h9) with any low-word reserved bit set raises `bad_desc` and no event. The reserved low-word bits are [3:0], [11:5] and [63:52].
- R5: A page group response with any high-word reserved bit set raises `bad_desc` and no event. The reserved high-word bits are [2:0] and [63:12].
- R6: A page group response with the PASID-present bit `desc_lo[4]` clear raises `bad_desc` and no event.
- R7: A legal page group response gives `rsp_vld`=1 in the next cycle, with these fields:
  - `rsp_rid` = `desc_lo[31:16]`
  - `rsp_pasid` = `desc_lo[51:32]`
  - `rsp_group` = `desc_hi[11:3]`
- R8: The 4-bit response code field `desc_lo[15:12]` maps to `rsp_code` as follows: 0 gives 2'b00 (success), 1 gives 2'b01 (invalid request), and any other value gives 2'b10 (failure).
- R9: Any other type code gives `bad_desc`=0 and `rsp_vld`=0, whatever the words hold.
- R10: Each result lasts one cycle. A cycle without a strobe is followed by `bad_desc`=0 and `rsp_vld`=0.
- R11: `bad_desc` and `rsp_vld` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| desc_vld | input | 1 | Descriptor strobe |
| desc_type | input | 4 | Descriptor type code |
| desc_lo | input | 64 | Low descriptor word |
| desc_hi | input | 64 | High descriptor word |
| bad_desc | output | 1 | Descriptor judged invalid (one cycle) |
| rsp_vld | output | 1 | Response event strobe (one cycle) |
| rsp_rid | output | 16 | Requester ID of the response |
| rsp_pasid | output | 20 | PASID of the response |
| rsp_group | output | 9 | Page request group index |
| rsp_code | output | 2 | Mapped response code |

## Verification
Several rules are checked by assertions on every cycle:
- the two result strobes never overlap;
- the outputs fall idle after a cycle without a strobe;
- a flagless wait is always rejected;
- unrelated types never react;
- the mapped code always follows the raw code field.

The bench's directed scenarios cover the rest:
- the field extraction, with distinct values;
- each reserved-bit region of both words;
- the fence-only wait;
- the reset state.

// File: rtl/iq_desc_pkg.sv
package iq_desc_pkg;

    localparam int TYPE_W   = 4;
    localparam int WORD_W   = 64;
    localparam int RID_W    = 16;
    localparam int PASID_W  = 20;
    localparam int GRP_W    = 9;
    localparam int RCODE_W  = 4;
    localparam int NFLAG    = 3;

    localparam logic [TYPE_W-1:0] TYPE_WAIT   = 4'h5;
    localparam logic [TYPE_W-1:0] TYPE_GRPRSP = 4'h9;

    // wait descriptor flag field
    localparam int FLAG_LSB  = 4;

    // page group response field positions
    localparam int PP_BIT    = 4;
    localparam int RCODE_LSB = 12;
    localparam int RID_LSB   = 16;
    localparam int PASID_LSB = 32;
    localparam int GRP_LSB   = 3;

    typedef enum logic [1:0] {
        RSP_SUCCESS = 2'b00,
        RSP_INVREQ  = 2'b01,
        RSP_FAILURE = 2'b10
    } rsp_code_e;

    typedef struct packed {
        logic [RID_W-1:0]   rid;
        logic [PASID_W-1:0] pasid;
        logic [GRP_W-1:0]   grp;
        rsp_code_e          code;
    } rsp_evt_t;

    function automatic logic [WORD_W-1:0] field_mask(input int width, input int lsb);
        logic [WORD_W-1:0] m;
        m = ((WORD_W'(1) << width) - WORD_W'(1)) << lsb;
        return m;
    endfunction

    function automatic logic [WORD_W-1:0] lo_used_mask();
        return field_mask(1, PP_BIT) | field_mask(RCODE_W, RCODE_LSB) |
               field_mask(RID_W, RID_LSB) | field_mask(PASID_W, PASID_LSB);
    endfunction

    function automatic logic [WORD_W-1:0] hi_used_mask();
        return field_mask(GRP_W, GRP_LSB);
    endfunction

    function automatic rsp_code_e map_code(input logic [RCODE_W-1:0] raw);
        rsp_code_e c;
        if (raw == RCODE_W'(0))      c = RSP_SUCCESS;
        else if (raw == RCODE_W'(1)) c = RSP_INVREQ;
        else                         c = RSP_FAILURE;
        return c;
    endfunction

endpackage

// File: rtl/iq_wait_check.sv
module iq_wait_check
    import iq_desc_pkg::*;
#(
    parameter int N_FLAGS = NFLAG
) (
    input  logic [N_FLAGS-1:0] flags,
    output logic               legal
);
    // any flag set is enough; fence alone needs no further action
    always_comb legal = |flags;
endmodule

// File: rtl/iq_grprsp_decode.sv
module iq_grprsp_decode
    import iq_desc_pkg::*;
(
    input  logic [WORD_W-1:0] lo,
    input  logic [WORD_W-1:0] hi,
    output logic              legal,
    output rsp_evt_t          evt
);
    localparam logic [WORD_W-1:0] LO_RSVD = ~lo_used_mask();
    localparam logic [WORD_W-1:0] HI_RSVD = ~hi_used_mask();

    logic rsvd_hit;
    logic pp;

    always_comb begin
        rsvd_hit  = |(lo & LO_RSVD) || |(hi & HI_RSVD);
        pp        = lo[PP_BIT];
        legal     = !rsvd_hit && pp;
        evt.rid   = lo[RID_LSB +: RID_W];
        evt.pasid = lo[PASID_LSB +: PASID_W];
        evt.grp   = hi[GRP_LSB +: GRP_W];
        evt.code  = map_code(lo[RCODE_LSB +: RCODE_W]);
    end
endmodule

// File: rtl/iq_desc_checker.sv
module iq_desc_checker
    import iq_desc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 desc_vld,
    input  logic [TYPE_W-1:0]    desc_type,
    input  logic [WORD_W-1:0]    desc_lo,
    input  logic [WORD_W-1:0]    desc_hi,
    output logic                 bad_desc,
    output logic                 rsp_vld,
    output logic [RID_W-1:0]     rsp_rid,
    output logic [PASID_W-1:0]   rsp_pasid,
    output logic [GRP_W-1:0]     rsp_group,
    output logic [1:0]           rsp_code
);
    logic     wait_ok;
    logic     grp_ok;
    rsp_evt_t grp_evt;
    logic     is_wait, is_grp;
    logic     bad_nxt, evt_nxt;
    rsp_evt_t evt_q;

    iq_wait_check #(.N_FLAGS(NFLAG)) u_wait (
        .flags (desc_lo[FLAG_LSB +: NFLAG]),
        .legal (wait_ok)
    );

    iq_grprsp_decode u_grp (
        .lo    (desc_lo),
        .hi    (desc_hi),
        .legal (grp_ok),
        .evt   (grp_evt)
    );

    always_comb begin
        is_wait = desc_vld && (desc_type == TYPE_WAIT);
        is_grp  = desc_vld && (desc_type == TYPE_GRPRSP);
        bad_nxt = (is_wait && !wait_ok) || (is_grp && !grp_ok);
        evt_nxt = is_grp && grp_ok;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bad_desc <= 1'b0;
            rsp_vld  <= 1'b0;
            evt_q    <= '0;
        end else begin
            bad_desc <= bad_nxt;
            rsp_vld  <= evt_nxt;
            if (evt_nxt) evt_q <= grp_evt;
        end
    end

    assign rsp_rid   = evt_q.rid;
    assign rsp_pasid = evt_q.pasid;
    assign rsp_group = evt_q.grp;
    assign rsp_code  = evt_q.code;

    p_wait_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (desc_vld && desc_type == TYPE_WAIT && desc_lo[FLAG_LSB +: NFLAG] == '0) |=> bad_desc)
        else $error("wait without flags not rejected");

    p_wait_ok_r3: assert property (@(posedge clk) disable iff (rst)
        (desc_vld && desc_type == TYPE_WAIT && desc_lo[FLAG_LSB +: NFLAG] != '0) |=> (!bad_desc && !rsp_vld))
        else $error("legal wait reacted");

    p_no_pp_r6: assert property (@(posedge clk) disable iff (rst)
        (desc_vld && desc_type == TYPE_GRPRSP && !desc_lo[PP_BIT]) |=> (bad_desc && !rsp_vld))
        else $error("response without PASID accepted");

    p_other_r9: assert property (@(posedge clk) disable iff (rst)
        (desc_vld && desc_type != TYPE_WAIT && desc_type != TYPE_GRPRSP) |=> (!bad_desc && !rsp_vld))
        else $error("unrelated type reacted");

    p_idle_r10: assert property (@(posedge clk) disable iff (rst)
        !desc_vld |=> (!bad_desc && !rsp_vld))
        else $error("result outlasted one cycle");

    p_excl_r11: assert property (@(posedge clk) disable iff (rst)
        !(bad_desc && rsp_vld))
        else $error("invalid and event together");

    p_code_map_r8: assert property (@(posedge clk) disable iff (rst)
        (desc_vld && desc_type == TYPE_GRPRSP && desc_lo[RCODE_LSB +: RCODE_W] > RCODE_W'(1))
        |=> (!rsp_vld || rsp_code == 2'b10))
        else $error("unknown code not mapped to failure");
endmodule

// File: tb/iq_desc_checker_tb.sv
module iq_desc_checker_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        desc_vld;
    logic [3:0]  desc_type;
    logic [63:0] desc_lo, desc_hi;
    logic        bad_desc, rsp_vld;
    logic [15:0] rsp_rid;
    logic [19:0] rsp_pasid;
    logic [8:0]  rsp_group;
    logic [1:0]  rsp_code;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    iq_desc_checker dut_i (
        .clk(clk), .rst(rst), .desc_vld(desc_vld), .desc_type(desc_type),
        .desc_lo(desc_lo), .desc_hi(desc_hi), .bad_desc(bad_desc),
        .rsp_vld(rsp_vld), .rsp_rid(rsp_rid), .rsp_pasid(rsp_pasid),
        .rsp_group(rsp_group), .rsp_code(rsp_code)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] grp_lo(input logic [15:0] rid, input logic [19:0] pasid,
                                           input logic [3:0] code, input logic pp);
        return {12'h0, pasid, rid, code, 7'h0, pp, 4'h0};
    endfunction

    function automatic logic [63:0] grp_hi(input logic [8:0] grp);
        return {52'h0, grp, 3'h0};
    endfunction

    // drive one strobe at a falling edge, leave outputs to be sampled at the next falling edge
    task automatic send(input logic [3:0] t, input logic [63:0] lo, input logic [63:0] hi);
        @(negedge clk);
        desc_vld = 1'b1; desc_type = t; desc_lo = lo; desc_hi = hi;
        @(negedge clk);
        desc_vld = 1'b0;
    endtask

    task automatic expect_out(input string req, input logic b, input logic v);
        check({req, " bad_desc"}, 64'(bad_desc), 64'(b));
        check({req, " rsp_vld"},  64'(rsp_vld),  64'(v));
    endtask

    task automatic t_reset();
        rst = 1'b1; desc_vld = 1'b0; desc_type = 4'h5; desc_lo = '0; desc_hi = '0;
        repeat (3) @(negedge clk);
        expect_out("R1 in reset", 1'b0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        expect_out("R1 after reset", 1'b0, 1'b0);
    endtask

    task automatic t_wait();
        send(4'h5, 64'h0, 64'h0);
        expect_out("R2 flagless wait", 1'b1, 1'b0);
        @(negedge clk);
        expect_out("R10 idle after result", 1'b0, 1'b0);
        for (int f = 1; f < 8; f++) begin
            send(4'h5, 64'(f) << 4, 64'h0);
            expect_out($sformatf("R3 wait flags=%0d", f), 1'b0, 1'b0);
        end
        send(4'h5, 64'h40, 64'h0);
        expect_out("R3 fence-only wait", 1'b0, 1'b0);
    endtask

    task automatic t_grp_good();
        send(4'h9, grp_lo(16'hBEEF, 20'hA5C3E, 4'h0, 1'b1), grp_hi(9'h1A7));
        expect_out("R7 legal response", 1'b0, 1'b1);
        check("R7 rid",   64'(rsp_rid),   64'hBEEF);
        check("R7 pasid", 64'(rsp_pasid), 64'hA5C3E);
        check("R7 group", 64'(rsp_group), 64'h1A7);
        check("R8 code 0", 64'(rsp_code), 64'h0);
        @(negedge clk);
        expect_out("R10 event one cycle", 1'b0, 1'b0);
        send(4'h9, grp_lo(16'h0102, 20'h00003, 4'h1, 1'b1), grp_hi(9'h001));
        check("R8 code 1", 64'(rsp_code), 64'h1);
        check("R7 rid second", 64'(rsp_rid), 64'h0102);
        for (int c = 2; c < 16; c++) begin
            send(4'h9, grp_lo(16'h0055, 20'h0000F, 4'(c), 1'b1), grp_hi(9'h0F0));
            check($sformatf("R8 code %0d vld", c), 64'(rsp_vld), 64'h1);
            check($sformatf("R8 code %0d", c), 64'(rsp_code), 64'h2);
        end
    endtask

    task automatic t_grp_bad();
        logic [63:0] good_lo;
        good_lo = grp_lo(16'h1234, 20'h54321, 4'h0, 1'b1);
        send(4'h9, good_lo | 64'h0000_0000_0000_0001, grp_hi(9'h3));
        expect_out("R4 lo rsvd bit0", 1'b1, 1'b0);
        send(4'h9, good_lo | 64'h0000_0000_0000_0800, grp_hi(9'h3));
        expect_out("R4 lo rsvd bit11", 1'b1, 1'b0);
        send(4'h9, good_lo | 64'h8000_0000_0000_0000, grp_hi(9'h3));
        expect_out("R4 lo rsvd bit63", 1'b1, 1'b0);
        send(4'h9, good_lo, grp_hi(9'h3) | 64'h4);
        expect_out("R5 hi rsvd bit2", 1'b1, 1'b0);
        send(4'h9, good_lo, grp_hi(9'h3) | 64'h1000);
        expect_out("R5 hi rsvd bit12", 1'b1, 1'b0);
        send(4'h9, grp_lo(16'h1234, 20'h54321, 4'h0, 1'b0), grp_hi(9'h3));
        expect_out("R6 no PASID", 1'b1, 1'b0);
    endtask

    task automatic t_other();
        for (int t = 0; t < 16; t++) begin
            if (t == 5 || t == 9) continue;
            send(4'(t), 64'h0, 64'hFFFF_FFFF_FFFF_FFFF);
            expect_out($sformatf("R9 type %0d", t), 1'b0, 1'b0);
        end
        // R11: back-to-back invalid then legal, checking exclusivity each cycle
        @(negedge clk);
        desc_vld = 1'b1; desc_type = 4'h5; desc_lo = '0; desc_hi = '0;
        @(negedge clk);
        desc_type = 4'h9; desc_lo = grp_lo(16'h7, 20'h8, 4'h0, 1'b1); desc_hi = grp_hi(9'h9);
        expect_out("R11 invalid first", 1'b1, 1'b0);
        @(negedge clk);
        desc_vld = 1'b0;
        expect_out("R11 event second", 1'b0, 1'b1);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_wait();
                t_grp_good();
                t_grp_bad();
                t_other();
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired actual=running expected=done");
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule